// File: doc/BRIEF.md
# Calendar Real-Time Clock with Masked Alarm

This peripheral keeps calendar time as eight counters: seconds, minutes, hours, day of the month, day of the week, day of the year, month and year. A one-cycle pulse on `tick` comes from a slow time base. On each pulse the counters advance by one second, as long as counting is enabled. Months have their real lengths, and February gets a 29th day in years divisible by four. Software stops the clock, loads each field through its own register, and starts the clock again. It reads the running time either field by field or as three packed snapshot words.

Eight alarm compare registers hold a target value for each field. A mask excludes any subset of fields from the comparison. When every compared field matches right after an advance, a sticky alarm flag is raised. A second sticky flag records that a field selected by the increment-enable register changed. Writing 1 to a flag bit clears it, and the flags are ORed onto one interrupt line. All access goes through a simple synchronous bus. Writes take effect on the clock edge, and read data is a combinational function of the address.

Top module: `rtc_calendar`

## Requirements
- R1: After reset, every register reads zero except the alarm mask (address 0x10), which reads 0xFF. `irq` is low.
- R2: The packed words have this layout. Word 0x14 holds seconds in [5:0], minutes in [13:8], hours in [20:16] and day of week in [26:24]. Word 0x18 holds day of month in [4:0], month in [11:8] and year in [27:16]. Word 0x1C holds day of year in [11:0]. All other bits read zero.
- R3: Control bit 0 (address 0x08) enables counting. While it is 0, a tick changes nothing and field writes are accepted. While it is 1, writes to the time fields are ignored.
- R4: Seconds and minutes wrap from 59 to 0, and each wrap carries into the next field. Hours wrap from 23 to 0.
- R5: An hour wrap advances the day. Day of month and day of year increment, and day of week counts 0 to 6 and wraps to 0.
- R6: Month lengths are 31 days, or 30 for months 4, 6, 9 and 11. Month 2 has 29 days when year[1:0]==0 and 28 otherwise. The day after the last day of a month is day 1 of the next month. After month 12 comes month 1 of the next year, with day of year set to 1.
- R7: Field i sits at address 0x20+4*i and its alarm at 0x60+4*i. The order of i is sec, min, hour, dom, dow, doy, month, year. Stored values are truncated to the field widths 6, 6, 5, 5, 3, 12, 4, 12, and reads return them zero-extended.
- R8: Flag bit 0 (address 0x00) is set on an advance in which any field changes whose bit i is set in the increment-enable register (0x0C). The bit order follows the R7 field order.
- R9: Flag bit 1 is set one cycle after an advance, if every field whose mask bit is 0 equals its alarm register at that point. The mask bits follow the R7 field order. Writes made while stopped never set the flag.
- R10: A mask value of 0xFF never sets the alarm flag.
- R11: Writing 1 to a flag bit clears it. Writing 0 leaves it unchanged.
- R12: `irq` is high exactly while either flag bit is set.
- R13: Control bit 4 is stored and read back but does not affect counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse per second from the time base |
| busAddr | input | ADDR_W | Byte address of the register |
| busWe | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr` |
| irq | output | 1 | OR of both sticky flags |

## Verification
A wrong carry or month-length decision shows up in the packed words on the first read after the faulty tick. The table-driven vectors therefore start one second before each rollover boundary, so every carry path is decided by a single pulse. A wrong alarm compare or mask decode shows up on flag bit 1 and `irq` one cycle after the tick. The bench samples both the cycle before and the cycle after that point, which also catches a flag that rises a cycle early. A write accepted while counting shows up on the next read of the field.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int NUM_FIELDS = 8;
  localparam int FIELD_W    = 12;
  localparam int DATA_W     = 32;

  typedef struct packed {
    logic [11:0] year;
    logic [3:0]  month;
    logic [11:0] doy;
    logic [2:0]  dow;
    logic [4:0]  dom;
    logic [4:0]  hour;
    logic [5:0]  min;
    logic [5:0]  sec;
  } calTime_t;

  typedef struct packed {
    logic                  advance;
    logic [NUM_FIELDS-1:0] wrTime;
    logic [NUM_FIELDS-1:0] wrAlarm;
    logic [FIELD_W-1:0]    wrVal;
  } dpStrobe_t;

  function automatic logic [FIELD_W-1:0] widthMask(input int unsigned idx);
    case (idx)
      0, 1:    return 12'h03F;
      2, 3:    return 12'h01F;
      4:       return 12'h007;
      6:       return 12'h00F;
      5, 7:    return 12'hFFF;
      default: return 12'h000;
    endcase
  endfunction

  function automatic logic [FIELD_W-1:0] getField(input calTime_t t, input int unsigned idx);
    case (idx)
      0:       return FIELD_W'(t.sec);
      1:       return FIELD_W'(t.min);
      2:       return FIELD_W'(t.hour);
      3:       return FIELD_W'(t.dom);
      4:       return FIELD_W'(t.dow);
      5:       return t.doy;
      6:       return FIELD_W'(t.month);
      default: return t.year;
    endcase
  endfunction

  function automatic calTime_t setField(input calTime_t t, input int unsigned idx,
                                        input logic [FIELD_W-1:0] val);
    calTime_t r;
    r = t;
    case (idx)
      0:       r.sec   = val[5:0];
      1:       r.min   = val[5:0];
      2:       r.hour  = val[4:0];
      3:       r.dom   = val[4:0];
      4:       r.dow   = val[2:0];
      5:       r.doy   = val;
      6:       r.month = val[3:0];
      default: r.year  = val;
    endcase
    return r;
  endfunction

  function automatic logic [4:0] monthDays(input logic [3:0] m, input logic [11:0] y);
    case (m)
      4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
      4'd2:                    return (y[1:0] == 2'b00) ? 5'd29 : 5'd28;
      default:                 return 5'd31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_cal_datapath.sv
module rtc_cal_datapath
  import rtc_cal_pkg::*;
(
  input  logic                                  clk,
  input  logic                                  rstN,
  input  dpStrobe_t                             strobe,
  output calTime_t                              timeNow,
  output logic [NUM_FIELDS-1:0]                 changedVec,
  output logic [NUM_FIELDS-1:0]                 matchVec,
  output logic [NUM_FIELDS-1:0][FIELD_W-1:0]    alarmVals
);
  calTime_t curTime, nxtTime;
  logic secWrap, minWrap, hourWrap, dayCarry, monthEnd, yearEnd;

  assign secWrap  = curTime.sec  >= 6'd59;
  assign minWrap  = curTime.min  >= 6'd59;
  assign hourWrap = curTime.hour >= 5'd23;
  assign dayCarry = secWrap && minWrap && hourWrap;
  assign monthEnd = curTime.dom >= monthDays(curTime.month, curTime.year);
  assign yearEnd  = monthEnd && (curTime.month >= 4'd12);

  always_comb begin
    nxtTime = curTime;
    if (strobe.advance) begin
      nxtTime.sec = secWrap ? 6'd0 : curTime.sec + 6'd1;
      if (secWrap)
        nxtTime.min = minWrap ? 6'd0 : curTime.min + 6'd1;
      if (secWrap && minWrap)
        nxtTime.hour = hourWrap ? 5'd0 : curTime.hour + 5'd1;
      if (dayCarry) begin
        nxtTime.dow = (curTime.dow >= 3'd6) ? 3'd0 : curTime.dow + 3'd1;
        nxtTime.dom = monthEnd ? 5'd1 : curTime.dom + 5'd1;
        nxtTime.doy = yearEnd ? 12'd1 : curTime.doy + 12'd1;
        if (yearEnd) begin
          nxtTime.month = 4'd1;
          nxtTime.year  = curTime.year + 12'd1;
        end else if (monthEnd) begin
          nxtTime.month = curTime.month + 4'd1;
        end
      end
    end
    for (int unsigned i = 0; i < NUM_FIELDS; i++)
      if (strobe.wrTime[i]) nxtTime = setField(nxtTime, i, strobe.wrVal);
  end

  always_ff @(posedge clk) begin
    if (!rstN) curTime <= '0;
    else       curTime <= nxtTime;
  end

  always_comb begin
    for (int unsigned i = 0; i < NUM_FIELDS; i++)
      changedVec[i] = strobe.advance && (getField(nxtTime, i) != getField(curTime, i));
  end

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : gAlarm
    logic [FIELD_W-1:0] alarmReg;
    always_ff @(posedge clk) begin
      if (!rstN)                 alarmReg <= '0;
      else if (strobe.wrAlarm[g]) alarmReg <= strobe.wrVal & widthMask(g);
    end
    assign alarmVals[g] = alarmReg;
    assign matchVec[g]  = (getField(curTime, g) == alarmReg);
  end

  assign timeNow = curTime;
endmodule

// File: rtl/rtc_cal_ctrl.sv
module rtc_cal_ctrl
  import rtc_cal_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               tick,
  input  logic [ADDR_W-1:0]                  busAddr,
  input  logic                               busWe,
  input  logic [DATA_W-1:0]                  busWdata,
  output logic [DATA_W-1:0]                  busRdata,
  output logic                               irq,
  input  calTime_t                           timeNow,
  input  logic [NUM_FIELDS-1:0]              changedVec,
  input  logic [NUM_FIELDS-1:0]              matchVec,
  input  logic [NUM_FIELDS-1:0][FIELD_W-1:0] alarmVals,
  output dpStrobe_t                          strobe,
  output logic                               runEn,
  output logic [NUM_FIELDS-1:0]              alarmMask,
  output logic                               incFlag,
  output logic                               alarmFlag
);
  localparam logic [1:0] REGION_MISC  = 2'b00;
  localparam logic [1:0] REGION_TIME  = 2'b01;
  localparam logic [1:0] REGION_ALARM = 2'b11;

  logic                  hiOk, calDis, advDly, advance;
  logic [1:0]            region;
  logic [2:0]            slot;
  logic [NUM_FIELDS-1:0] incEn, wrTimeVec, wrAlarmVec;
  logic                  miscWe, flagWe, ctrlWe, incEnWe, maskWe, setInc, setAlarm;

  assign hiOk   = (busAddr >> 7) == '0;
  assign region = busAddr[6:5];
  assign slot   = busAddr[4:2];
  assign miscWe = busWe && hiOk && (region == REGION_MISC);
  assign flagWe  = miscWe && (slot == 3'd0);
  assign ctrlWe  = miscWe && (slot == 3'd2);
  assign incEnWe = miscWe && (slot == 3'd3);
  assign maskWe  = miscWe && (slot == 3'd4);
  assign advance = tick && runEn;

  always_comb begin
    for (int unsigned i = 0; i < NUM_FIELDS; i++) begin
      wrTimeVec[i]  = busWe && hiOk && !runEn && (region == REGION_TIME) && (slot == 3'(i));
      wrAlarmVec[i] = busWe && hiOk && (region == REGION_ALARM) && (slot == 3'(i));
    end
    strobe.advance = advance;
    strobe.wrTime  = wrTimeVec;
    strobe.wrAlarm = wrAlarmVec;
    strobe.wrVal   = busWdata[FIELD_W-1:0];
  end

  assign setInc   = advance && |(changedVec & incEn);
  assign setAlarm = advDly && (alarmMask != '1) && &(matchVec | alarmMask);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runEn     <= 1'b0;
      calDis    <= 1'b0;
      incEn     <= '0;
      alarmMask <= '1;
      advDly    <= 1'b0;
      incFlag   <= 1'b0;
      alarmFlag <= 1'b0;
    end else begin
      advDly <= advance;
      if (ctrlWe) begin
        runEn  <= busWdata[0];
        calDis <= busWdata[4];
      end
      if (incEnWe) incEn     <= busWdata[NUM_FIELDS-1:0];
      if (maskWe)  alarmMask <= busWdata[NUM_FIELDS-1:0];
      if (flagWe && busWdata[0]) incFlag   <= 1'b0;
      if (setInc)                incFlag   <= 1'b1;
      if (flagWe && busWdata[1]) alarmFlag <= 1'b0;
      if (setAlarm)              alarmFlag <= 1'b1;
    end
  end

  assign irq = incFlag | alarmFlag;

  always_comb begin
    busRdata = '0;
    if (hiOk) begin
      case (region)
        REGION_TIME:  busRdata = DATA_W'(getField(timeNow, 32'(slot)));
        REGION_ALARM: busRdata = DATA_W'(alarmVals[slot]);
        REGION_MISC: begin
          case (slot)
            3'd0: busRdata = {30'b0, alarmFlag, incFlag};
            3'd2: busRdata = {27'b0, calDis, 3'b0, runEn};
            3'd3: busRdata = DATA_W'(incEn);
            3'd4: busRdata = DATA_W'(alarmMask);
            3'd5: busRdata = {5'b0, timeNow.dow, 3'b0, timeNow.hour, 2'b0,
                              timeNow.min, 2'b0, timeNow.sec};
            3'd6: busRdata = {4'b0, timeNow.year, 4'b0, timeNow.month, 3'b0, timeNow.dom};
            3'd7: busRdata = {20'b0, timeNow.doy};
            default: busRdata = '0;
          endcase
        end
        default: busRdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              irq
);
  dpStrobe_t                          strobe;
  calTime_t                           curTime;
  logic [NUM_FIELDS-1:0]              changedVec, matchVec, alarmMask;
  logic [NUM_FIELDS-1:0][FIELD_W-1:0] alarmVals;
  logic                               runEn, incFlag, alarmFlag;

  rtc_cal_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick),
    .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata), .busRdata(busRdata),
    .irq(irq), .timeNow(curTime), .changedVec(changedVec), .matchVec(matchVec),
    .alarmVals(alarmVals), .strobe(strobe), .runEn(runEn), .alarmMask(alarmMask),
    .incFlag(incFlag), .alarmFlag(alarmFlag)
  );

  rtc_cal_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .timeNow(curTime),
    .changedVec(changedVec), .matchVec(matchVec), .alarmVals(alarmVals)
  );
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk
  import rtc_cal_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  tick,
  input logic                  busWe,
  input logic [ADDR_W-1:0]     busAddr,
  input logic [31:0]           busWdata,
  input logic                  irq,
  input logic                  runEn,
  input logic [NUM_FIELDS-1:0] alarmMask,
  input logic                  incFlag,
  input logic                  alarmFlag,
  input calTime_t              curTime
);
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rstN)
    (!runEn && !busWe) |=> $stable(curTime)); // R3
  AST_RUN_NO_TICK_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && !tick) |=> $stable(curTime)); // R3
  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && tick && curTime.sec == 6'd59) |=> (curTime.sec == 6'd0)); // R4
  AST_INC_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(incFlag) |-> $past(tick && runEn)); // R8
  AST_MASK_OFF_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(alarmFlag) |-> ($past(alarmMask) != 8'hFF)); // R10
  AST_ZERO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == '0 && !busWdata[0] && incFlag) |=> incFlag); // R11
  AST_IRQ_FALL_BY_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irq) |-> $past(busWe && busAddr == '0)); // R12
endmodule

bind rtc_calendar rtc_calendar_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/rtc_calendar_tb.sv
`timescale 1ns/1ps
module rtc_calendar_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irq;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rtc_calendar u_dut (.clk(clk), .rstN(rstN), .tick(tick), .busAddr(busAddr),
    .busWe(busWe), .busWdata(busWdata), .busRdata(busRdata), .irq(irq));

  // rows: sec,min,hour,dom,dow,doy,month,year start, then same order expected
  localparam int NV = 11;
  localparam int VEC [NV][16] = '{
    '{10,5,3,15,2,100,6,2023,   11,5,3,15,2,100,6,2023},
    '{59,5,3,15,2,100,6,2023,   0,6,3,15,2,100,6,2023},
    '{59,59,3,15,2,100,6,2023,  0,0,4,15,2,100,6,2023},
    '{59,59,23,15,2,100,6,2023, 0,0,0,16,3,101,6,2023},
    '{59,59,23,15,6,100,6,2023, 0,0,0,16,0,101,6,2023},
    '{59,59,23,30,1,120,4,2023, 0,0,0,1,2,121,5,2023},
    '{59,59,23,28,3,59,2,2023,  0,0,0,1,4,60,3,2023},
    '{59,59,23,28,3,59,2,2024,  0,0,0,29,4,60,2,2024},
    '{59,59,23,29,4,60,2,2024,  0,0,0,1,5,61,3,2024},
    '{59,59,23,31,0,365,12,2023,0,0,0,1,1,1,1,2024},
    '{59,59,23,31,2,31,1,2024,  0,0,0,1,3,32,2,2024}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic pulse();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic loadTime(input int s, input int mi, input int h, input int dm,
                          input int dw, input int dy, input int mo, input int y);
    wr(8'h20, s); wr(8'h24, mi); wr(8'h28, h); wr(8'h2C, dm);
    wr(8'h30, dw); wr(8'h34, dy); wr(8'h38, mo); wr(8'h3C, y);
  endtask

  function automatic logic [31:0] pack0(input int s, input int mi, input int h, input int dw);
    return (32'(dw) << 24) | (32'(h) << 16) | (32'(mi) << 8) | 32'(s);
  endfunction
  function automatic logic [31:0] pack1(input int dm, input int mo, input int y);
    return (32'(y) << 16) | (32'(mo) << 8) | 32'(dm);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired before end of test");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    rd(8'h00, d); check("R1 flags", d, 32'h0);
    rd(8'h08, d); check("R1 control", d, 32'h0);
    rd(8'h10, d); check("R1 mask", d, 32'hFF);
    rd(8'h14, d); check("R1 word0", d, 32'h0);
    rd(8'h18, d); check("R1 word1", d, 32'h0);
    rd(8'h60, d); check("R1 alarm sec", d, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);

    // table of rollover vectors
    for (int v = 0; v < NV; v++) begin
      wr(8'h08, 32'h0);
      loadTime(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3],
               VEC[v][4], VEC[v][5], VEC[v][6], VEC[v][7]);
      wr(8'h08, 32'h1);
      pulse();
      wr(8'h08, 32'h0);
      rd(8'h14, d);
      check($sformatf("R2 R4 R5 word0 vec%0d", v), d,
            pack0(VEC[v][8], VEC[v][9], VEC[v][10], VEC[v][12]));
      rd(8'h18, d);
      check($sformatf("R2 R6 word1 vec%0d", v), d,
            pack1(VEC[v][11], VEC[v][14], VEC[v][15]));
      rd(8'h1C, d);
      check($sformatf("R5 R6 word2 vec%0d", v), d, 32'(VEC[v][13]));
    end
    wr(8'h00, 32'h3);

    // R3 stopped hold and write lockout while running
    loadTime(10, 5, 3, 15, 2, 100, 6, 2023);
    pulse();
    rd(8'h20, d); check("R3 stopped tick holds", d, 32'd10);
    wr(8'h08, 32'h1);
    wr(8'h20, 32'd40);
    wr(8'h08, 32'h0);
    rd(8'h20, d); check("R3 write while running ignored", d, 32'd10);

    // R7 truncation and alarm readback
    wr(8'h20, 32'hFF); rd(8'h20, d); check("R7 sec width", d, 32'h3F);
    wr(8'h3C, 32'h1ABC); rd(8'h3C, d); check("R7 year width", d, 32'hABC);
    wr(8'h70, 32'hFF); rd(8'h70, d); check("R7 alarm dow width", d, 32'h7);
    wr(8'h70, 32'h0);

    // R13 calibration bit stored, no effect on counting
    loadTime(10, 5, 3, 15, 2, 100, 6, 2023);
    wr(8'h08, 32'h11);
    rd(8'h08, d); check("R13 control readback", d, 32'h11);
    pulse();
    wr(8'h08, 32'h10);
    rd(8'h20, d); check("R13 counting unaffected", d, 32'd11);

    // R8 increment flag, R11 write-one-to-clear, R12 irq
    wr(8'h0C, 32'h01);
    wr(8'h08, 32'h1);
    pulse();
    rd(8'h00, d); check("R8 sec change sets flag", d, 32'h1);
    check("R12 irq high", {31'b0, irq}, 32'h1);
    wr(8'h00, 32'h0);
    rd(8'h00, d); check("R11 zero write no effect", d, 32'h1);
    wr(8'h00, 32'h1);
    rd(8'h00, d); check("R11 one write clears", d, 32'h0);
    check("R12 irq low", {31'b0, irq}, 32'h0);
    wr(8'h0C, 32'h02);
    pulse();
    rd(8'h00, d); check("R8 unselected field silent", d, 32'h0);
    wr(8'h08, 32'h0);
    wr(8'h20, 32'd59);
    wr(8'h08, 32'h1);
    pulse();
    rd(8'h00, d); check("R8 minute change sets flag", d, 32'h1);
    wr(8'h08, 32'h0);
    wr(8'h00, 32'h3);
    wr(8'h0C, 32'h0);

    // R9 alarm, seconds only compared
    loadTime(20, 5, 3, 15, 2, 100, 6, 2023);
    wr(8'h60, 32'd21);
    wr(8'h10, 32'hFE);
    wr(8'h08, 32'h1);
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    busAddr = 8'h00;
    #1 check("R9 flag not yet set", busRdata, 32'h0);
    @(negedge clk);
    #1 check("R9 flag one cycle later", busRdata, 32'h2);
    check("R12 irq from alarm", {31'b0, irq}, 32'h1);
    wr(8'h08, 32'h0);
    wr(8'h00, 32'h2);

    // R9 full compare, match then mismatch
    loadTime(20, 5, 3, 15, 2, 100, 6, 2023);
    wr(8'h64, 32'd5); wr(8'h68, 32'd3); wr(8'h6C, 32'd15); wr(8'h70, 32'd2);
    wr(8'h74, 32'd100); wr(8'h78, 32'd6); wr(8'h7C, 32'd2023);
    wr(8'h10, 32'h00);
    wr(8'h08, 32'h1); pulse(); wr(8'h08, 32'h0);
    rd(8'h00, d); check("R9 all fields match", d, 32'h2);
    wr(8'h00, 32'h2);
    loadTime(20, 5, 3, 15, 2, 100, 6, 2023);
    wr(8'h7C, 32'd2024);
    wr(8'h08, 32'h1); pulse(); wr(8'h08, 32'h0);
    rd(8'h00, d); check("R9 year mismatch no flag", d, 32'h0);
    wr(8'h7C, 32'd2023);
    loadTime(21, 5, 3, 15, 2, 100, 6, 2023);
    repeat (2) @(negedge clk);
    rd(8'h00, d); check("R9 stopped write no flag", d, 32'h0);

    // R10 mask all ones disables
    loadTime(20, 5, 3, 15, 2, 100, 6, 2023);
    wr(8'h10, 32'hFF);
    wr(8'h08, 32'h1); pulse(); wr(8'h08, 32'h0);
    rd(8'h00, d); check("R10 disabled alarm", d, 32'h0);
    check("R10 irq stays low", {31'b0, irq}, 32'h0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule